// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the combinational arithmetic stage of a 32-bit integer datapath. From two operands and a short operation code it produces a result word, a flag that is set when that word is all zeros, and a flag that reports two's-complement overflow. It covers the register and immediate forms of addition and subtraction, bitwise logic, signed and unsigned less-than comparison, and shifts. It also covers a pass-through used when a constant has already been placed in the upper half of the B operand by the immediate path.

Every shift acts on operand B. The distance comes either from the 5-bit `shamt_i` input, for constant shifts, or from the low five bits of operand A, for variable shifts. The block holds no state. Its outputs follow its inputs within the same cycle and are registered by whatever stage consumes them. Multiplication and division are handled elsewhere.

Top module: `alu_int_core`

## Requirements
- R1: Operation codes on `op_sel` are: 0 add, 1 add-unsigned, 2 subtract, 3 subtract-unsigned, 4 and, 5 or, 6 xor, 7 nor, 8 signed less-than, 9 unsigned less-than, 10 constant left shift, 11 constant logical right shift, 12 constant arithmetic right shift, 13 variable left shift, 14 variable logical right shift, 15 variable arithmetic right shift, 16 B pass-through. Add and subtract (codes 0 to 3) give A+B and A-B modulo 2^32.
- R2: `ovf_o` is 1 only for codes 0 and 2, and only when the signed result does not fit in 32 bits. It is 0 for every other code, including codes 1 and 3, which return the same result as codes 0 and 2.
- R3: Codes 4 to 7 give the bitwise A&B, A|B, A^B and ~(A|B).
- R4: Code 8 gives 1 when A < B as signed two's-complement numbers and 0 otherwise. This includes operand pairs whose difference overflows.
- R5: Code 9 gives 1 when A < B as unsigned numbers and 0 otherwise.
- R6: Codes 10 to 12 shift B by `shamt_i`. A left shift fills the low bits with zeros. A distance of 0 returns B unchanged.
- R7: A logical right shift fills vacated high bits with zeros. An arithmetic right shift fills them with bit 31 of B.
- R8: Codes 13 to 15 shift B by the low 5 bits of A. Higher bits of A and the value on `shamt_i` have no effect on the result.
- R9: Code 16 returns B unchanged, whatever the value of A.
- R10: `zero_o` is 1 exactly when the 32-bit result is zero.
- R11: Codes 17 to 31 return a zero result with `ovf_o` at 0. `shamt_i` has no effect on codes 0 to 9 or 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Operand A (rs value); supplies the distance for variable shifts |
| opnd_b | input | 32 | Operand B (rt value or extended immediate); shift source |
| shamt_i | input | 5 | Constant shift distance from the instruction |
| op_sel | input | 5 | Operation code |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed add/subtract overflow |

## Verification
All three outputs are due in the same cycle as the inputs that produce them, after zero register stages. The bench drives each stimulus just after a rising edge. It samples result, zero flag and overflow flag on the following falling edge, half a period later, when the combinational paths have settled and no edge is being processed. Each table entry and directed case compares all three outputs at that one point and attributes any mismatch to the requirement that governs the field that differs.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,
        OP_SLTU = 5'd9,
        OP_SHL  = 5'd10,
        OP_SHR  = 5'd11,
        OP_SHA  = 5'd12,
        OP_SHLV = 5'd13,
        OP_SHRV = 5'd14,
        OP_SHAV = 5'd15,
        OP_PASB = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [2:0] {
        SRC_ZERO  = 3'd0,
        SRC_ARITH = 3'd1,
        SRC_LOGIC = 3'd2,
        SRC_LTS   = 3'd3,
        SRC_LTU   = 3'd4,
        SRC_SHIFT = 3'd5,
        SRC_PASSB = 3'd6
    } res_src_e;

endpackage

// File: rtl/alu_int_addsub.sv
module alu_int_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             lt_s_o,
    output logic             lt_u_o
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    assign b_eff = b_i ^ {WIDTH{sub_i}};
    assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};

    assign sum_o   = full[WIDTH-1:0];
    assign carry_o = full[WIDTH];
    // signed overflow: same-sign inputs giving an opposite-sign sum
    assign ovf_o   = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);
    // true sign of the difference despite wraparound
    assign lt_s_o  = sum_o[WIDTH-1] ^ ovf_o;
    // no carry out of A + ~B + 1 means a borrow
    assign lt_u_o  = ~carry_o;
endmodule

// File: rtl/alu_int_logic.sv
module alu_int_logic
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_fn_e        fn_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (fn_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            LG_NOR:  y_o = ~(a_i | b_i);
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_int_shift.sv
module alu_int_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [WIDTH-1:0] din_rev;
    logic [WIDTH-1:0] last_rev;
    logic [WIDTH-1:0] stage [SHW+1];
    logic             fill;

    // left shifts reuse the right-shift network on a bit-reversed word
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            din_rev[i]  = din_i[WIDTH-1-i];
            last_rev[i] = stage[SHW][WIDTH-1-i];
        end
    end

    assign fill     = arith_i & ~left_i & din_i[WIDTH-1];
    assign stage[0] = left_i ? din_rev : din_i;

    generate
        for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = amt_i[s]
                ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
                : stage[s];
        end
    endgenerate

    assign dout_o = left_i ? last_rev : stage[SHW];
endmodule

// File: rtl/alu_int_core.sv
module alu_int_core
    import alu_int_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SHW-1:0]   shamt_i,
    input  logic [4:0]       op_sel,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             ovf_o
);
    alu_op_e          op;
    logic             do_sub;
    logic             ovf_en;
    logic_fn_e        lg_fn;
    res_src_e         src;
    logic             sh_left;
    logic             sh_arith;
    logic             sh_var;
    logic [SHW-1:0]   sh_amt;

    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             ovf_raw;
    logic             lt_s;
    logic             lt_u;
    logic [WIDTH-1:0] lg_y;
    logic [WIDTH-1:0] sh_y;

    assign op = alu_op_e'(op_sel);

    // operation decode
    always_comb begin
        do_sub   = 1'b0;
        ovf_en   = 1'b0;
        lg_fn    = LG_AND;
        src      = SRC_ZERO;
        sh_left  = 1'b0;
        sh_arith = 1'b0;
        sh_var   = 1'b0;
        unique case (op)
            OP_ADD:  begin src = SRC_ARITH; ovf_en = 1'b1; end
            OP_ADDU: begin src = SRC_ARITH; end
            OP_SUB:  begin src = SRC_ARITH; do_sub = 1'b1; ovf_en = 1'b1; end
            OP_SUBU: begin src = SRC_ARITH; do_sub = 1'b1; end
            OP_AND:  begin src = SRC_LOGIC; lg_fn = LG_AND; end
            OP_OR:   begin src = SRC_LOGIC; lg_fn = LG_OR;  end
            OP_XOR:  begin src = SRC_LOGIC; lg_fn = LG_XOR; end
            OP_NOR:  begin src = SRC_LOGIC; lg_fn = LG_NOR; end
            OP_SLT:  begin src = SRC_LTS; do_sub = 1'b1; end
            OP_SLTU: begin src = SRC_LTU; do_sub = 1'b1; end
            OP_SHL:  begin src = SRC_SHIFT; sh_left = 1'b1; end
            OP_SHR:  begin src = SRC_SHIFT; end
            OP_SHA:  begin src = SRC_SHIFT; sh_arith = 1'b1; end
            OP_SHLV: begin src = SRC_SHIFT; sh_left = 1'b1; sh_var = 1'b1; end
            OP_SHRV: begin src = SRC_SHIFT; sh_var = 1'b1; end
            OP_SHAV: begin src = SRC_SHIFT; sh_arith = 1'b1; sh_var = 1'b1; end
            OP_PASB: begin src = SRC_PASSB; end
            default: begin src = SRC_ZERO; end
        endcase
    end

    assign sh_amt = sh_var ? opnd_a[SHW-1:0] : shamt_i;

    alu_int_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .sub_i   (do_sub),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf_raw),
        .lt_s_o  (lt_s),
        .lt_u_o  (lt_u)
    );

    alu_int_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i  (opnd_a),
        .b_i  (opnd_b),
        .fn_i (lg_fn),
        .y_o  (lg_y)
    );

    alu_int_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .din_i   (opnd_b),
        .amt_i   (sh_amt),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .dout_o  (sh_y)
    );

    // result select
    always_comb begin
        unique case (src)
            SRC_ARITH: result_o = sum;
            SRC_LOGIC: result_o = lg_y;
            SRC_LTS:   result_o = {{(WIDTH-1){1'b0}}, lt_s};
            SRC_LTU:   result_o = {{(WIDTH-1){1'b0}}, lt_u};
            SRC_SHIFT: result_o = sh_y;
            SRC_PASSB: result_o = opnd_b;
            default:   result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;
    assign ovf_o  = ovf_en & ovf_raw;
endmodule

// File: rtl/alu_int_chk.sv
module alu_int_chk #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [SHW-1:0]   shamt_i,
    input logic [4:0]       op_sel,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             ovf_o
);
    always_comb begin
        // R2
        ovf_mask_chk: assert (!(op_sel != 5'd0 && op_sel != 5'd2 && ovf_o));
        // R4
        slt_width_chk: assert (!(op_sel == 5'd8 && result_o[WIDTH-1:1] != '0));
        // R5
        sltu_width_chk: assert (!(op_sel == 5'd9 && result_o[WIDTH-1:1] != '0));
        // R9
        passb_chk: assert (!(op_sel == 5'd16 && result_o != opnd_b));
        // R6
        const_noshift_chk: assert (!(op_sel >= 5'd10 && op_sel <= 5'd12
                                     && shamt_i == '0 && result_o != opnd_b));
        // R8
        var_noshift_chk: assert (!(op_sel >= 5'd13 && op_sel <= 5'd15
                                   && opnd_a[SHW-1:0] == '0 && result_o != opnd_b));
        // R7
        sra_sign_chk: assert (!((op_sel == 5'd12 || op_sel == 5'd15)
                                && result_o[WIDTH-1] != opnd_b[WIDTH-1]));
        // R10
        xor_self_zero_chk: assert (!(op_sel == 5'd6 && opnd_a == opnd_b && !zero_o));
    end
endmodule

bind alu_int_core alu_int_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .shamt_i  (shamt_i),
    .op_sel   (op_sel),
    .result_o (result_o),
    .zero_o   (zero_o),
    .ovf_o    (ovf_o)
);

// File: tb/tb_alu_int_core.sv
module tb_alu_int_core;

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        z;
        logic        v;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  32'h00000005, 32'h00000007, 5'd31, 32'h0000000C, 1'b0, 1'b0},
        '{5'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0, 1'b1},
        '{5'd0,  32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1, 1'b1},
        '{5'd1,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0, 1'b0},
        '{5'd2,  32'h00000003, 32'h00000003, 5'd7,  32'h00000000, 1'b1, 1'b0},
        '{5'd2,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0, 1'b1},
        '{5'd3,  32'h00000000, 32'h00000001, 5'd0,  32'hFFFFFFFF, 1'b0, 1'b0},
        '{5'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0, 1'b0},
        '{5'd4,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hF000F000, 1'b0, 1'b0},
        '{5'd5,  32'hF0F0F0F0, 32'h0F0F0F0F, 5'd0,  32'hFFFFFFFF, 1'b0, 1'b0},
        '{5'd6,  32'hAAAA5555, 32'hFFFF0000, 5'd0,  32'h55555555, 1'b0, 1'b0},
        '{5'd7,  32'h00000000, 32'h00000000, 5'd0,  32'hFFFFFFFF, 1'b0, 1'b0},
        '{5'd7,  32'hFFFFFFFF, 32'h00000000, 5'd0,  32'h00000000, 1'b1, 1'b0},
        '{5'd8,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 1'b0, 1'b0},
        '{5'd8,  32'h80000000, 32'h7FFFFFFF, 5'd0,  32'h00000001, 1'b0, 1'b0},
        '{5'd8,  32'h7FFFFFFF, 32'h80000000, 5'd0,  32'h00000000, 1'b1, 1'b0},
        '{5'd9,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b1, 1'b0},
        '{5'd9,  32'h00000001, 32'h00000002, 5'd0,  32'h00000001, 1'b0, 1'b0},
        '{5'd10, 32'hFFFFFFFF, 32'h00000001, 5'd31, 32'h80000000, 1'b0, 1'b0},
        '{5'd10, 32'h00000000, 32'h12345678, 5'd4,  32'h23456780, 1'b0, 1'b0},
        '{5'd11, 32'h00000000, 32'h80000000, 5'd31, 32'h00000001, 1'b0, 1'b0},
        '{5'd12, 32'h00000000, 32'h80000000, 5'd4,  32'hF8000000, 1'b0, 1'b0},
        '{5'd12, 32'h00000000, 32'h40000000, 5'd4,  32'h04000000, 1'b0, 1'b0},
        '{5'd12, 32'h00000000, 32'h87654321, 5'd0,  32'h87654321, 1'b0, 1'b0},
        '{5'd13, 32'h00000024, 32'h00000001, 5'd31, 32'h00000010, 1'b0, 1'b0},
        '{5'd14, 32'hFFFFFFE1, 32'h80000000, 5'd0,  32'h40000000, 1'b0, 1'b0},
        '{5'd15, 32'h0000003F, 32'h80000000, 5'd0,  32'hFFFFFFFF, 1'b0, 1'b0},
        '{5'd16, 32'h00001234, 32'hABCD0000, 5'd9,  32'hABCD0000, 1'b0, 1'b0},
        '{5'd17, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd3,  32'h00000000, 1'b1, 1'b0},
        '{5'd31, 32'hFFFFFFFF, 32'h00000001, 5'd1,  32'h00000000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt_i = '0;
    logic [4:0]  op_sel = '0;
    logic [31:0] result_o;
    logic        zero_o;
    logic        ovf_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    alu_int_core dut (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .shamt_i  (shamt_i),
        .op_sel   (op_sel),
        .result_o (result_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o)
    );

    function automatic string req_of(input logic [4:0] op);
        if (op <= 5'd3)       return "R1";
        else if (op <= 5'd7)  return "R3";
        else if (op == 5'd8)  return "R4";
        else if (op == 5'd9)  return "R5";
        else if (op == 5'd11 || op == 5'd12) return "R7";
        else if (op == 5'd10) return "R6";
        else if (op <= 5'd15) return "R8";
        else if (op == 5'd16) return "R9";
        else                  return "R11";
    endfunction

    // drive after a rising edge, sample on the next falling edge
    task automatic apply(input vec_t v, input string tag);
        logic bad;
        @(posedge clk);
        #1;
        opnd_a  = v.a;
        opnd_b  = v.b;
        shamt_i = v.sh;
        op_sel  = v.op;
        @(negedge clk);
        n_checks++;
        bad = 1'b0;
        if (result_o !== v.res) begin
            $display("FAIL %s %s op=%0d result actual=%h expected=%h",
                     req_of(v.op), tag, v.op, result_o, v.res);
            bad = 1'b1;
        end
        if (zero_o !== v.z) begin
            $display("FAIL R10 %s op=%0d zero actual=%b expected=%b", tag, v.op, zero_o, v.z);
            bad = 1'b1;
        end
        if (ovf_o !== v.v) begin
            $display("FAIL R2 %s op=%0d ovf actual=%b expected=%b", tag, v.op, ovf_o, v.v);
            bad = 1'b1;
        end
        if (bad) n_fail++;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // idle state: all-zero inputs select add of zeros (R10)
        apply('{5'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b1, 1'b0}, "idle");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], "table");
        end

        // R8: high bits of A ignored, shamt_i ignored on variable shifts
        apply('{5'd13, 32'hFFFFFFE3, 32'h0000000F, 5'd20, 32'h00000078, 1'b0, 1'b0}, "R8_high_a");
        apply('{5'd14, 32'h00000020, 32'hDEADBEEF, 5'd8,  32'hDEADBEEF, 1'b0, 1'b0}, "R8_wrap32");
        // R11: shamt_i has no effect on arithmetic and compare ops
        apply('{5'd2,  32'h00000010, 32'h00000001, 5'd31, 32'h0000000F, 1'b0, 1'b0}, "R11_sub_sh");
        apply('{5'd9,  32'h00000000, 32'hFFFFFFFF, 5'd17, 32'h00000001, 1'b0, 1'b0}, "R11_sltu_sh");
        // R2: negative overflow on subtract, none on unsigned form
        apply('{5'd2,  32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b0, 1'b1}, "R2_sub_ovf");
        apply('{5'd1,  32'h80000000, 32'h80000000, 5'd0, 32'h00000000, 1'b1, 1'b0}, "R2_addu_mask");
        // R6: constant left shift fills zeros from below
        apply('{5'd10, 32'h0000001F, 32'hFFFFFFFF, 5'd1, 32'hFFFFFFFE, 1'b0, 1'b0}, "R6_fill");
        // R7: logical right shift of a negative value fills zeros
        apply('{5'd11, 32'h0, 32'hF0000000, 5'd4, 32'h0F000000, 1'b0, 1'b0}, "R7_srl_neg");
        // R9: pass-through unaffected by A
        apply('{5'd16, 32'hFFFFFFFF, 32'h00000000, 5'd0, 32'h00000000, 1'b1, 1'b0}, "R9_zero_b");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule